// File: doc/BRIEF.md
# Two-Bank Word-Interleaved Memory Controller

This block gives two requesters, an I/O channel port and a processor port, shared access to a word memory split into two banks of equal size that cycle independently. Each port presents byte addresses, but every transfer moves one whole 32-bit word. Consecutive words alternate between the two banks, so sequential traffic from one port, or traffic from both ports at once, tends to land on different banks. Requests to different banks are accepted in the same cycle and both banks run together. When both ports want the same idle bank, the I/O channel port wins and the processor port waits until that bank is free again.

Every stored word carries four odd parity bits, one per byte. These bits are produced on each write and checked on each read. The ports never see them: read data is 32 bits wide, and a failed check shows up as an error flag beside the returned data. Writes carry a byte-enable mask. A partial write merges the new bytes into the stored word and regenerates all four parity bits. A test-only fault input flips one stored parity bit, so that the checker can be exercised.

Each request side uses a valid/ready handshake. A requester raises valid with the command, address, data and mask, and holds all of them unchanged until it sees ready high in the same cycle. Ready is high for exactly the cycle in which the request is accepted. A port may issue a new request in the cycle after acceptance. The return path has no back-pressure: a read result appears as a one-cycle data-valid strobe that the requester must take.

Top module: `dual_bank_mem`

## Requirements
- R1: A byte address A selects bank A[2] and word index A[ADDR_W-1:3] inside that bank. A[1:0] has no effect, so addresses that differ only in those bits reach the same word.
- R2: When both ports are valid and their addresses differ in bit 2, and both banks are idle, both ports see ready high in that same cycle.
- R3: When both ports are valid for the same idle bank, only the I/O port sees ready. The processor port is accepted BUSY_CYC+1 cycles later.
- R4: After a bank accepts a request in cycle t, it accepts no request from either port in cycles t+1 to t+BUSY_CYC, and this includes the I/O port. It may accept again in cycle t+BUSY_CYC+1.
- R5: A read accepted in cycle t raises that port's rsp_valid for the single cycle t+BUSY_CYC+1, with the stored word on rsp_rdata. The other port's rsp_valid stays low for it.
- R6: On a write, be bit k enables byte k (data bits 8k+7:8k). Bytes whose be bit is 0 keep their stored value.
- R7: A read of any word last written through a port, with either a full or a partial mask, returns rsp_perr = 0.
- R8: A pulse on fault_valid inverts the stored parity bit for byte lane fault_lane of the word at fault_addr. The next read of that word returns the unchanged data with rsp_perr = 1. A later full write of that word makes rsp_perr read 0 again.
- R9: During reset and in the first cycle after it, with no request valid, ready and rsp_valid are low on both ports.
- R10: A write produces no rsp_valid strobe on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_req_valid | input | 1 | I/O port request valid |
| io_req_ready | output | 1 | I/O port request accepted this cycle |
| io_req_write | input | 1 | I/O port: 1 for write, 0 for read |
| io_req_addr | input | ADDR_W | I/O port byte address |
| io_req_wdata | input | 32 | I/O port write data |
| io_req_be | input | 4 | I/O port byte enables |
| io_rsp_valid | output | 1 | I/O port read data strobe |
| io_rsp_rdata | output | 32 | I/O port read data |
| io_rsp_perr | output | 1 | I/O port parity error on this read |
| cpu_req_valid | input | 1 | Processor port request valid |
| cpu_req_ready | output | 1 | Processor port request accepted this cycle |
| cpu_req_write | input | 1 | Processor port: 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Processor port byte address |
| cpu_req_wdata | input | 32 | Processor port write data |
| cpu_req_be | input | 4 | Processor port byte enables |
| cpu_rsp_valid | output | 1 | Processor port read data strobe |
| cpu_rsp_rdata | output | 32 | Processor port read data |
| cpu_rsp_perr | output | 1 | Processor port parity error on this read |
| fault_valid | input | 1 | Test-only: flip one stored parity bit |
| fault_addr | input | ADDR_W | Test-only: byte address of the word to corrupt |
| fault_lane | input | 2 | Test-only: byte lane whose parity bit is flipped |

## Verification
The hardest case to reach is a bank collision that is spread across two cycles. In that case the processor takes a bank, and the I/O port asks for the same bank one cycle later. The I/O port must then wait despite its priority, while a request to the other bank is accepted at once. The stimulus covers this by sweeping every pair of words in a 16-word configuration, once with both requests starting in the same cycle and once with the I/O request one cycle behind. The acceptance cycle of each port is recorded and compared with the arithmetic expectation. Parity faults cannot be reached from the request ports at all, so every word and lane is corrupted through the fault input, read back, and then repaired with a full write.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int NUM_BANKS = 2;
  localparam int LANES     = 4;
  localparam int DATA_W    = 8 * LANES;
  localparam int PAR_W     = LANES;
  localparam int WORD_W    = DATA_W + PAR_W;
  localparam int BANK_BIT  = 2;  // byte address bit that picks the bank

  typedef enum logic {SRC_IO = 1'b0, SRC_CPU = 1'b1} src_e;

  // one odd parity bit per byte lane
  function automatic logic [PAR_W-1:0] odd_parity(input logic [DATA_W-1:0] d);
    logic [PAR_W-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = ~(^d[i*8 +: 8]);
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_d,
                                                    input logic [DATA_W-1:0] new_d,
                                                    input logic [LANES-1:0]  be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = be[i] ? new_d[i*8 +: 8] : old_d[i*8 +: 8];
    return m;
  endfunction
endpackage

// File: rtl/dbm_arbiter.sv
module dbm_arbiter
  import dbm_pkg::*;
(
  input  logic                 io_valid,
  input  logic                 io_bank,
  input  logic                 cpu_valid,
  input  logic                 cpu_bank,
  input  logic [NUM_BANKS-1:0] bank_busy,
  output logic                 io_grant,
  output logic                 cpu_grant,
  output logic [NUM_BANKS-1:0] bank_start,
  output logic [NUM_BANKS-1:0] bank_from_cpu
);
  logic [NUM_BANKS-1:0] io_hit;
  logic [NUM_BANKS-1:0] cpu_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic SEL = 1'(b);
    logic io_wants;
    logic cpu_wants;
    assign io_wants  = io_valid  && (io_bank  == SEL);
    assign cpu_wants = cpu_valid && (cpu_bank == SEL);
    // a busy bank refuses everyone; the I/O port wins a tie on an idle bank
    assign io_hit[b]        = io_wants && !bank_busy[b];
    assign cpu_hit[b]       = cpu_wants && !bank_busy[b] && !io_wants;
    assign bank_start[b]    = io_hit[b] || cpu_hit[b];
    assign bank_from_cpu[b] = cpu_hit[b];
  end

  assign io_grant  = |io_hit;
  assign cpu_grant = |cpu_hit;
endmodule

// File: rtl/dbm_bank.sv
module dbm_bank
  import dbm_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [LANES-1:0]  start_be,
  input  src_e              start_src,
  input  logic              fault_en,
  input  logic [IDX_W-1:0]  fault_idx,
  input  logic [1:0]        fault_lane,
  output logic              busy,
  output logic              done,
  output src_e              done_src,
  output logic [DATA_W-1:0] done_rdata,
  output logic              done_perr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic              op_write;
  logic [IDX_W-1:0]  op_idx;
  logic [DATA_W-1:0] op_wdata;
  logic [LANES-1:0]  op_be;
  src_e              op_src;

  logic              finish;
  logic [WORD_W-1:0] stored;
  logic [DATA_W-1:0] old_data;
  logic [DATA_W-1:0] merged;
  logic              bad_par;
  logic [PAR_W-1:0]  flip_mask;

  assign busy     = (cnt != '0);
  assign finish   = (cnt == CNT_LAST);
  assign stored   = mem[op_idx];
  assign old_data = stored[DATA_W-1:0];
  assign bad_par  = |(stored[WORD_W-1:DATA_W] ^ odd_parity(old_data));
  assign merged   = merge_lanes(old_data, op_wdata, op_be);

  always_comb begin
    flip_mask = '0;
    flip_mask[fault_lane] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      op_write <= 1'b0;
      op_idx   <= '0;
      op_wdata <= '0;
      op_be    <= '0;
      op_src   <= SRC_IO;
    end else if (start) begin
      cnt      <= CNT_LOAD;
      op_write <= start_write;
      op_idx   <= start_idx;
      op_wdata <= start_wdata;
      op_be    <= start_be;
      op_src   <= start_src;
    end else if (busy) begin
      cnt <= cnt - CNT_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      done_src   <= SRC_IO;
      done_rdata <= '0;
      done_perr  <= 1'b0;
    end else begin
      done <= finish && !op_write;
      if (finish && !op_write) begin
        done_src   <= op_src;
        done_rdata <= old_data;
        done_perr  <= bad_par;
      end
    end
  end

  // storage: the read-modify-write lands in the last busy cycle; the fault
  // port only touches the array when no write completes that cycle
  always_ff @(posedge clk) begin
    if (finish && op_write) begin
      mem[op_idx] <= {odd_parity(merged), merged};
    end else if (fault_en) begin
      mem[fault_idx] <= mem[fault_idx] ^ {flip_mask, {DATA_W{1'b0}}};
    end
  end
endmodule

// File: rtl/dbm_return.sv
module dbm_return
  import dbm_pkg::*;
(
  input  logic              bank_done  [NUM_BANKS],
  input  src_e              bank_src   [NUM_BANKS],
  input  logic [DATA_W-1:0] bank_rdata [NUM_BANKS],
  input  logic              bank_perr  [NUM_BANKS],
  output logic              io_valid,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_perr,
  output logic              cpu_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_perr
);
  // a port owns at most one completing bank per cycle, since its grants
  // are one per cycle and every bank cycle has the same length
  always_comb begin
    io_valid  = 1'b0;
    io_rdata  = '0;
    io_perr   = 1'b0;
    cpu_valid = 1'b0;
    cpu_rdata = '0;
    cpu_perr  = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_done[b] && bank_src[b] == SRC_IO) begin
        io_valid = 1'b1;
        io_rdata = bank_rdata[b];
        io_perr  = bank_perr[b];
      end
      if (bank_done[b] && bank_src[b] == SRC_CPU) begin
        cpu_valid = 1'b1;
        cpu_rdata = bank_rdata[b];
        cpu_perr  = bank_perr[b];
      end
    end
  end
endmodule

// File: rtl/dual_bank_mem.sv
module dual_bank_mem
  import dbm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req_valid,
  output logic              io_req_ready,
  input  logic              io_req_write,
  input  logic [ADDR_W-1:0] io_req_addr,
  input  logic [31:0]       io_req_wdata,
  input  logic [3:0]        io_req_be,
  output logic              io_rsp_valid,
  output logic [31:0]       io_rsp_rdata,
  output logic              io_rsp_perr,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [31:0]       cpu_req_wdata,
  input  logic [3:0]        cpu_req_be,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rsp_rdata,
  output logic              cpu_rsp_perr,
  input  logic              fault_valid,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [1:0]        fault_lane
);
  localparam int IDX_W = ADDR_W - BANK_BIT - 1;

  logic             io_bank, cpu_bank, fault_bank;
  logic [IDX_W-1:0] io_idx, cpu_idx, fault_idx;

  assign io_bank    = io_req_addr[BANK_BIT];
  assign cpu_bank   = cpu_req_addr[BANK_BIT];
  assign fault_bank = fault_addr[BANK_BIT];
  assign io_idx     = io_req_addr[ADDR_W-1:BANK_BIT+1];
  assign cpu_idx    = cpu_req_addr[ADDR_W-1:BANK_BIT+1];
  assign fault_idx  = fault_addr[ADDR_W-1:BANK_BIT+1];

  logic unused_lane_bits;
  assign unused_lane_bits = ^{io_req_addr[BANK_BIT-1:0], cpu_req_addr[BANK_BIT-1:0],
                              fault_addr[BANK_BIT-1:0]};

  logic [NUM_BANKS-1:0] bank_busy;
  logic [NUM_BANKS-1:0] bank_start;
  logic [NUM_BANKS-1:0] bank_from_cpu;
  logic                 bank_done  [NUM_BANKS];
  src_e                 bank_src   [NUM_BANKS];
  logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];
  logic                 bank_perr  [NUM_BANKS];

  dbm_arbiter u_arb (
    .io_valid      (io_req_valid),
    .io_bank       (io_bank),
    .cpu_valid     (cpu_req_valid),
    .cpu_bank      (cpu_bank),
    .bank_busy     (bank_busy),
    .io_grant      (io_req_ready),
    .cpu_grant     (cpu_req_ready),
    .bank_start    (bank_start),
    .bank_from_cpu (bank_from_cpu)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic SEL = 1'(b);
    logic             st_write;
    logic [IDX_W-1:0] st_idx;
    logic [31:0]      st_wdata;
    logic [3:0]       st_be;
    src_e             st_src;

    assign st_src   = bank_from_cpu[b] ? SRC_CPU : SRC_IO;
    assign st_write = bank_from_cpu[b] ? cpu_req_write : io_req_write;
    assign st_idx   = bank_from_cpu[b] ? cpu_idx       : io_idx;
    assign st_wdata = bank_from_cpu[b] ? cpu_req_wdata : io_req_wdata;
    assign st_be    = bank_from_cpu[b] ? cpu_req_be    : io_req_be;

    dbm_bank #(.IDX_W(IDX_W), .BUSY_CYC(BUSY_CYC)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (bank_start[b]),
      .start_write (st_write),
      .start_idx   (st_idx),
      .start_wdata (st_wdata),
      .start_be    (st_be),
      .start_src   (st_src),
      .fault_en    (fault_valid && (fault_bank == SEL)),
      .fault_idx   (fault_idx),
      .fault_lane  (fault_lane),
      .busy        (bank_busy[b]),
      .done        (bank_done[b]),
      .done_src    (bank_src[b]),
      .done_rdata  (bank_rdata[b]),
      .done_perr   (bank_perr[b])
    );
  end

  dbm_return u_ret (
    .bank_done  (bank_done),
    .bank_src   (bank_src),
    .bank_rdata (bank_rdata),
    .bank_perr  (bank_perr),
    .io_valid   (io_rsp_valid),
    .io_rdata   (io_rsp_rdata),
    .io_perr    (io_rsp_perr),
    .cpu_valid  (cpu_rsp_valid),
    .cpu_rdata  (cpu_rsp_rdata),
    .cpu_perr   (cpu_rsp_perr)
  );
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
  parameter int ADDR_W   = 8,
  parameter int BUSY_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_req_valid,
  input logic              io_req_ready,
  input logic              io_req_write,
  input logic [ADDR_W-1:0] io_req_addr,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_write,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              io_rsp_valid,
  input logic              cpu_rsp_valid
);
  // accepted reads, delayed by the full bank cycle
  logic [BUSY_CYC:0] io_rd_pipe;
  logic [BUSY_CYC:0] cpu_rd_pipe;
  logic io_rd_acc, cpu_rd_acc;

  assign io_rd_acc  = io_req_valid  && io_req_ready  && !io_req_write;
  assign cpu_rd_acc = cpu_req_valid && cpu_req_ready && !cpu_req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rd_pipe  <= '0;
      cpu_rd_pipe <= '0;
    end else begin
      io_rd_pipe  <= {io_rd_pipe[BUSY_CYC-1:0], io_rd_acc};
      cpu_rd_pipe <= {cpu_rd_pipe[BUSY_CYC-1:0], cpu_rd_acc};
    end
  end

  AST_IO_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid == io_rd_pipe[BUSY_CYC]); // R5

  AST_CPU_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid == cpu_rd_pipe[BUSY_CYC]); // R10

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_req_ready || io_req_valid) && (!cpu_req_ready || cpu_req_valid)); // R2

  AST_DUAL_GRANT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_ready && cpu_req_ready) |-> (io_req_addr[2] != cpu_req_addr[2])); // R2

  AST_CONFLICT_IO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && cpu_req_ready) |-> (io_req_addr[2] != cpu_req_addr[2])); // R3

  AST_IO_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_ready |=> !(io_req_ready && io_req_addr[2] == $past(io_req_addr[2]))
                 && !(cpu_req_ready && cpu_req_addr[2] == $past(io_req_addr[2]))); // R4

  AST_CPU_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |=> !(io_req_ready && io_req_addr[2] == $past(cpu_req_addr[2]))
                  && !(cpu_req_ready && cpu_req_addr[2] == $past(cpu_req_addr[2]))); // R4
endmodule

bind dual_bank_mem dbm_checker #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .io_req_valid  (io_req_valid),
  .io_req_ready  (io_req_ready),
  .io_req_write  (io_req_write),
  .io_req_addr   (io_req_addr),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_write (cpu_req_write),
  .cpu_req_addr  (cpu_req_addr),
  .io_rsp_valid  (io_rsp_valid),
  .cpu_rsp_valid (cpu_rsp_valid)
);

// File: tb/dual_bank_mem_test.sv
module dual_bank_mem_test;
  localparam int AW    = 6;
  localparam int BC    = 3;
  localparam int WORDS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          io_req_valid = 0, io_req_write = 0;
  logic [AW-1:0] io_req_addr = '0;
  logic [31:0]   io_req_wdata = '0;
  logic [3:0]    io_req_be = '0;
  logic          cpu_req_valid = 0, cpu_req_write = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [31:0]   cpu_req_wdata = '0;
  logic [3:0]    cpu_req_be = '0;
  logic          fault_valid = 0;
  logic [AW-1:0] fault_addr = '0;
  logic [1:0]    fault_lane = '0;
  logic          io_req_ready, cpu_req_ready;
  logic          io_rsp_valid, cpu_rsp_valid, io_rsp_perr, cpu_rsp_perr;
  logic [31:0]   io_rsp_rdata, cpu_rsp_rdata;

  dual_bank_mem #(.ADDR_W(AW), .BUSY_CYC(BC)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] model [WORDS];
  logic [31:0] got_data;
  logic        got_perr;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input bit port, input bit v, input bit wr, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    if (!port) begin
      io_req_valid = v; io_req_write = wr; io_req_addr = a; io_req_wdata = d; io_req_be = be;
    end else begin
      cpu_req_valid = v; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d; cpu_req_be = be;
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? n[i*8 +: 8] : o[i*8 +: 8];
    return m;
  endfunction

  // one request on an idle controller; checks acceptance and response timing
  task automatic single_op(input bit port, input bit wr, input logic [AW-1:0] a,
                           input logic [31:0] d, input logic [3:0] be);
    int waitc = 0;
    bit rdy;
    @(negedge clk);
    drive(port, 1'b1, wr, a, d, be);
    #1;
    rdy = port ? cpu_req_ready : io_req_ready;
    while (!rdy && waitc < 20) begin
      @(negedge clk); #1; waitc++;
      rdy = port ? cpu_req_ready : io_req_ready;
    end
    check(waitc == 0, "R4 idle bank accepts at once", 64'(waitc), 64'd0);
    for (int k = 1; k <= BC + 1; k++) begin
      bit own_v, other_v, exp_v;
      @(negedge clk);
      if (k == 1) drive(port, 1'b0, 1'b0, '0, '0, '0);
      #1;
      own_v   = port ? cpu_rsp_valid : io_rsp_valid;
      other_v = port ? io_rsp_valid  : cpu_rsp_valid;
      exp_v   = !wr && (k == BC + 1);
      if (wr) check(own_v == 1'b0, "R10 no strobe for a write", 64'(own_v), 64'd0);
      else    check(own_v == exp_v, "R5 strobe cycle", 64'(own_v), 64'(exp_v));
      check(other_v == 1'b0, "R5 other port silent", 64'(other_v), 64'd0);
      if (exp_v) begin
        got_data = port ? cpu_rsp_rdata : io_rsp_rdata;
        got_perr = port ? cpu_rsp_perr  : io_rsp_perr;
      end
    end
  endtask

  // io request starts in cycle dly (0 or 1), cpu request in cycle 0
  task automatic pair_read(input int ia, input int ca, input int dly);
    int io_acc = -1, cpu_acc = -1, io_rc = -1, cpu_rc = -1, io_n = 0, cpu_n = 0;
    int e_io, e_cpu;
    logic [31:0] io_d = '0, cpu_d = '0;
    logic io_p = 0, cpu_p = 0;
    bit same;
    logic [3:0] iw, cw;
    iw = 4'(ia); cw = 4'(ca);
    same = (iw[0] == cw[0]);
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if (c == 0)   drive(1'b1, 1'b1, 1'b0, {cw, iw[1:0]}, '0, '0);
      if (c == dly) drive(1'b0, 1'b1, 1'b0, {iw, cw[1:0]}, '0, '0);
      if (io_acc >= 0 && io_acc == c - 1)   drive(1'b0, 1'b0, 1'b0, '0, '0, '0);
      if (cpu_acc >= 0 && cpu_acc == c - 1) drive(1'b1, 1'b0, 1'b0, '0, '0, '0);
      #1;
      if (io_req_valid && io_req_ready && io_acc < 0)    io_acc = c;
      if (cpu_req_valid && cpu_req_ready && cpu_acc < 0) cpu_acc = c;
      if (io_rsp_valid)  begin io_n++;  io_rc = c;  io_d = io_rsp_rdata;   io_p = io_rsp_perr;  end
      if (cpu_rsp_valid) begin cpu_n++; cpu_rc = c; cpu_d = cpu_rsp_rdata; cpu_p = cpu_rsp_perr; end
    end
    if (dly == 0) begin
      e_io = 0;  e_cpu = same ? BC + 1 : 0;
      check(io_acc == e_io, same ? "R3 io wins tie" : "R2 io accepted", 64'(io_acc), 64'(e_io));
      check(cpu_acc == e_cpu, same ? "R3 cpu waits" : "R2 cpu same cycle", 64'(cpu_acc), 64'(e_cpu));
    end else begin
      e_cpu = 0; e_io = same ? BC + 1 : 1;
      check(cpu_acc == e_cpu, "R4 cpu accepted", 64'(cpu_acc), 64'(e_cpu));
      check(io_acc == e_io, same ? "R4 busy bank holds io" : "R2 other bank free", 64'(io_acc), 64'(e_io));
    end
    check(io_n == 1 && io_rc == io_acc + BC + 1, "R5 io strobe cycle", 64'(io_rc), 64'(io_acc + BC + 1));
    check(cpu_n == 1 && cpu_rc == cpu_acc + BC + 1, "R5 cpu strobe cycle", 64'(cpu_rc), 64'(cpu_acc + BC + 1));
    check(io_d == model[ia], "R5 io data", 64'(io_d), 64'(model[ia]));
    check(cpu_d == model[ca], "R5 cpu data", 64'(cpu_d), 64'(model[ca]));
    check(!io_p && !cpu_p, "R7 pair parity clean", 64'({io_p, cpu_p}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    #1;
    check({io_req_ready, cpu_req_ready, io_rsp_valid, cpu_rsp_valid} == 4'b0,
          "R9 outputs low in reset", 64'({io_req_ready, cpu_req_ready, io_rsp_valid, cpu_rsp_valid}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check({io_req_ready, cpu_req_ready, io_rsp_valid, cpu_rsp_valid} == 4'b0,
          "R9 outputs low after reset", 64'({io_req_ready, cpu_req_ready, io_rsp_valid, cpu_rsp_valid}), 64'd0);

    // R1: fill every word with varying low address bits, read back with others
    for (int w = 0; w < WORDS; w++) begin
      logic [3:0] wv;
      wv = 4'(w);
      model[w] = 32'h9E37_79B9 * 32'(w + 1) ^ 32'h0F0F_3355;
      single_op(wv[1], 1'b1, {wv, wv[1:0]}, model[w], 4'hF);
    end
    for (int w = 0; w < WORDS; w++) begin
      logic [3:0] wv;
      wv = 4'(w);
      single_op(~wv[1], 1'b0, {wv, ~wv[1:0]}, '0, '0);
      check(got_data == model[w], "R1 word found through any low bits", 64'(got_data), 64'(model[w]));
      check(got_perr == 1'b0, "R7 full write parity clean", 64'(got_perr), 64'd0);
    end

    // R6: every byte-enable mask once
    for (int w = 0; w < WORDS; w++) begin
      logic [3:0] wv;
      logic [31:0] nd;
      wv = 4'(w);
      nd = ~model[w] ^ 32'(w * 32'h0101_0101);
      single_op(wv[0], 1'b1, {wv, 2'b00}, nd, wv);
      model[w] = merge(model[w], nd, wv);
      single_op(~wv[0], 1'b0, {wv, 2'b01}, '0, '0);
      check(got_data == model[w], "R6 masked merge", 64'(got_data), 64'(model[w]));
      check(got_perr == 1'b0, "R7 partial write parity clean", 64'(got_perr), 64'd0);
    end

    // R2 R3 R4: every word pair, same start and io one cycle late
    for (int dly = 0; dly < 2; dly++)
      for (int ia = 0; ia < WORDS; ia++)
        for (int ca = 0; ca < WORDS; ca++)
          pair_read(ia, ca, dly);

    // R8: corrupt each lane of each word, detect, repair
    for (int w = 0; w < WORDS; w++) begin
      for (int ln = 0; ln < 4; ln++) begin
        logic [3:0] wv;
        wv = 4'(w);
        @(negedge clk);
        fault_valid = 1'b1; fault_addr = {wv, 2'b10}; fault_lane = 2'(ln);
        @(negedge clk);
        fault_valid = 1'b0;
        single_op(wv[0] ^ 1'(ln), 1'b0, {wv, 2'b00}, '0, '0);
        check(got_perr == 1'b1, "R8 flipped parity detected", 64'(got_perr), 64'd1);
        check(got_data == model[w], "R8 data unchanged by flip", 64'(got_data), 64'(model[w]));
        single_op(1'b0, 1'b1, {wv, 2'b00}, model[w], 4'hF);
        single_op(1'b1, 1'b0, {wv, 2'b00}, '0, '0);
        check(got_perr == 1'b0, "R8 full write repairs parity", 64'(got_perr), 64'd0);
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule